// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block forms the data-memory address for a load or store that takes its address from a pointer held in two 8-bit registers. It also forms the value that goes back into that register pair. Per request it takes the two pointer bytes, the index of the pair, a two-bit addressing mode and an unsigned 6-bit displacement. One cycle later it presents the effective address with a strobe. With the same strobe it presents a write-back enable, the new pointer bytes and the index of the pair to update.

The same path serves byte reads from program memory, which always use the pair at register index 30. On that path the displacement is not used. Only the post-increment mode writes the pointer back, and every other mode reads at the pointer and leaves the pair as it is. The memories and the register file sit outside the block.

Top module: `ptr_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `strb_o` and `wb_en_o` are 0 after that edge, and `addr_o` is 0x0000.
- R2: The pointer is `{ptr_hi_i, ptr_lo_i}`. In mode 0 (plain) a data access uses the pointer as the address, and `wb_en_o` stays 0.
- R3: In mode 1 (pre-decrement) the address is pointer − 1. `wb_en_o` is 1, and `{wb_hi_o, wb_lo_o}` carries that same decremented value.
- R4: In mode 2 (post-increment) the address is the unmodified pointer. `wb_en_o` is 1, and `{wb_hi_o, wb_lo_o}` carries pointer + 1.
- R5: In mode 3 (displacement) the address is pointer + `disp_i`, with `disp_i` read as unsigned in the range 0 to 63. `wb_en_o` stays 0.
- R6: All pointer arithmetic wraps modulo 2^16. Pre-decrement of 0x0000 gives 0xFFFF, post-increment of 0xFFFF writes back 0x0000, and 0xFFF0 + 63 gives 0x002F.
- R7: When `prog_i` is 1, the address is the pointer in every mode and the displacement is ignored. `wb_idx_o` is 30. Only mode 2 sets `wb_en_o` (with pointer + 1); the other modes leave it 0.
- R8: A request accepted at a clock edge raises `strb_o` for exactly the following cycle. `wb_en_o` is never 1 without `strb_o`. A cycle with `req_i` low yields `strb_o` = 0 and `wb_en_o` = 0 after the next edge.
- R9: For a data access, `wb_idx_o` is `ptr_idx_i` with bit 0 cleared. That value is the even index of the low byte, and the high byte is at `wb_idx_o` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| prog_i | input | 1 | 1 = program-memory byte read through pair 30 |
| mode_i | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment, 3 displacement |
| disp_i | input | 6 | Unsigned displacement |
| ptr_lo_i | input | 8 | Pointer low byte |
| ptr_hi_i | input | 8 | Pointer high byte |
| ptr_idx_i | input | 5 | Register index of the pointer pair |
| strb_o | output | 1 | Address valid strobe |
| addr_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_lo_o | output | 8 | New pointer low byte |
| wb_hi_o | output | 8 | New pointer high byte |
| wb_idx_o | output | 5 | Even register index to write back |

## Verification
The assertions check on every cycle the relation between a request and its result one cycle later. They cover the address each mode produces, the written-back value, the absence of write-back in plain and displacement modes, the forced index and the single post-increment update on the program path, and that the write-back enable is only ever high together with the strobe. The bench's scenarios cover what a property alone cannot show: an arithmetic sweep over a wide spread of pointer values and every displacement. That sweep includes the modulo-2^16 wrap points and idle cycles that fall between back-to-back requests.

// File: rtl/agu_pkg.sv
// Shared types for the indirect pointer address generator.
// Assumes the mode encoding is fixed by the instruction decoder upstream.
package agu_pkg;
    typedef enum logic [1:0] {
        PM_PLAIN   = 2'd0,
        PM_PREDEC  = 2'd1,
        PM_POSTINC = 2'd2,
        PM_DISP    = 2'd3
    } ptr_mode_e;
endpackage

// File: rtl/agu_mode_filter.sv
// Resolves the effective mode and write-back index for a request.
// Program-memory reads keep only post-increment and always use pair Z_IDX.
// Assumes ptr_idx names the pair by either of its two register indices.
module agu_mode_filter
    import agu_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int Z_IDX = 30
) (
    input  logic             prog,
    input  ptr_mode_e        mode,
    input  logic [IDX_W-1:0] ptr_idx,
    output ptr_mode_e        eff_mode,
    output logic [IDX_W-1:0] wb_idx
);
    localparam logic [IDX_W-1:0] EVEN_MASK = ~IDX_W'(1);

    // Pick the mode and pair that the arithmetic stage must serve.
    always_comb begin
        if (prog) begin
            eff_mode = (mode == PM_POSTINC) ? PM_POSTINC : PM_PLAIN;
            wb_idx   = IDX_W'(Z_IDX);
        end else begin
            eff_mode = mode;
            wb_idx   = ptr_idx & EVEN_MASK;
        end
    end
endmodule

// File: rtl/agu_ptr_arith.sv
// Pointer arithmetic: effective address, next pointer value and update flag.
// All sums wrap modulo 2**AW. The displacement is zero-extended.
module agu_ptr_arith
    import agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DISP_W = 6
) (
    input  logic [AW-1:0]     ptr,
    input  ptr_mode_e         mode,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     ea,
    output logic [AW-1:0]     next_ptr,
    output logic              upd
);
    localparam int PAD_W = AW - DISP_W;

    logic [AW-1:0] dec_v;
    logic [AW-1:0] inc_v;
    logic [AW-1:0] off_v;

    // Candidate values, one adder each.
    always_comb begin
        dec_v = ptr - AW'(1);
        inc_v = ptr + AW'(1);
        off_v = ptr + {{PAD_W{1'b0}}, disp};
    end

    // Select address and write-back per mode.
    always_comb begin
        ea       = ptr;
        next_ptr = ptr;
        upd      = 1'b0;
        unique case (mode)
            PM_PLAIN:   ea = ptr;
            PM_PREDEC:  begin ea = dec_v; next_ptr = dec_v; upd = 1'b1; end
            PM_POSTINC: begin ea = ptr;   next_ptr = inc_v; upd = 1'b1; end
            PM_DISP:    ea = off_v;
            default:    ea = ptr;
        endcase
    end
endmodule

// File: rtl/agu_out_stage.sv
// Output register stage: strobe, address and write-back fields.
// Fields hold while idle; strobe and enable fall when no request is present.
module agu_out_stage #(
    parameter int AW    = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [AW-1:0]    ea,
    input  logic [AW-1:0]    next_ptr,
    input  logic             upd,
    input  logic [IDX_W-1:0] idx,
    output logic             strb,
    output logic [AW-1:0]    addr,
    output logic             wb_en,
    output logic [AW-1:0]    wb_val,
    output logic [IDX_W-1:0] wb_idx
);
    // Register one result per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb   <= 1'b0;
            wb_en  <= 1'b0;
            addr   <= '0;
            wb_val <= '0;
            wb_idx <= '0;
        end else begin
            strb  <= req;
            wb_en <= req & upd;
            if (req) begin
                addr   <= ea;
                wb_val <= next_ptr;
                wb_idx <= idx;
            end
        end
    end
endmodule

// File: rtl/ptr_addr_gen.sv
// Indirect pointer address generator top.
// Forms a data or program-memory address from a register-pair pointer and
// the value written back to that pair; one cycle of latency.
// Assumes the register file applies wb_* on the cycle strb_o is high.
module ptr_addr_gen
    import agu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 6,
    parameter int IDX_W  = 5,
    parameter int Z_IDX  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              prog_i,
    input  logic [1:0]        mode_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [BYTE_W-1:0] ptr_lo_i,
    input  logic [BYTE_W-1:0] ptr_hi_i,
    input  logic [IDX_W-1:0]  ptr_idx_i,
    output logic              strb_o,
    output logic [2*BYTE_W-1:0] addr_o,
    output logic              wb_en_o,
    output logic [BYTE_W-1:0] wb_lo_o,
    output logic [BYTE_W-1:0] wb_hi_o,
    output logic [IDX_W-1:0]  wb_idx_o
);
    localparam int AW = 2 * BYTE_W;

    ptr_mode_e        eff_mode;
    logic [IDX_W-1:0] sel_idx;
    logic [AW-1:0]    ptr;
    logic [AW-1:0]    ea;
    logic [AW-1:0]    next_ptr;
    logic             upd;
    logic [AW-1:0]    wb_val;

    // Join the pair: high byte above low byte.
    always_comb ptr = {ptr_hi_i, ptr_lo_i};

    agu_mode_filter #(.IDX_W(IDX_W), .Z_IDX(Z_IDX)) u_filter (
        .prog     (prog_i),
        .mode     (ptr_mode_e'(mode_i)),
        .ptr_idx  (ptr_idx_i),
        .eff_mode (eff_mode),
        .wb_idx   (sel_idx)
    );

    agu_ptr_arith #(.AW(AW), .DISP_W(DISP_W)) u_arith (
        .ptr      (ptr),
        .mode     (eff_mode),
        .disp     (disp_i),
        .ea       (ea),
        .next_ptr (next_ptr),
        .upd      (upd)
    );

    agu_out_stage #(.AW(AW), .IDX_W(IDX_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_i),
        .ea       (ea),
        .next_ptr (next_ptr),
        .upd      (upd),
        .idx      (sel_idx),
        .strb     (strb_o),
        .addr     (addr_o),
        .wb_en    (wb_en_o),
        .wb_val   (wb_val),
        .wb_idx   (wb_idx_o)
    );

    // Split the write-back value back into its two bytes.
    always_comb begin
        wb_lo_o = wb_val[BYTE_W-1:0];
        wb_hi_o = wb_val[AW-1:BYTE_W];
    end
endmodule

// File: rtl/ptr_addr_gen_chk.sv
// Checker for ptr_addr_gen: relates each request to its registered result.
module ptr_addr_gen_chk #(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 6,
    parameter int IDX_W  = 5,
    parameter int Z_IDX  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              prog_i,
    input logic [1:0]        mode_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [BYTE_W-1:0] ptr_lo_i,
    input logic [BYTE_W-1:0] ptr_hi_i,
    input logic [IDX_W-1:0]  ptr_idx_i,
    input logic              strb_o,
    input logic [2*BYTE_W-1:0] addr_o,
    input logic              wb_en_o,
    input logic [BYTE_W-1:0] wb_lo_o,
    input logic [BYTE_W-1:0] wb_hi_o,
    input logic [IDX_W-1:0]  wb_idx_o
);
    localparam int AW = 2 * BYTE_W;

    logic [AW-1:0] ptr_c;
    logic [AW-1:0] wbv_c;
    logic [AW-1:0] disp_c;
    always_comb begin
        ptr_c  = {ptr_hi_i, ptr_lo_i};
        wbv_c  = {wb_hi_o, wb_lo_o};
        disp_c = AW'(disp_i);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!strb_o && !wb_en_o && addr_o == '0));

    assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prog_i && mode_i == 2'd0) |=> (addr_o == $past(ptr_c) && !wb_en_o));

    assert_predec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prog_i && mode_i == 2'd1) |=>
        (addr_o == AW'($past(ptr_c) - AW'(1)) && wb_en_o && wbv_c == addr_o));

    assert_postinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'd2) |=>
        (addr_o == $past(ptr_c) && wb_en_o && wbv_c == AW'(addr_o + AW'(1))));

    assert_disp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prog_i && mode_i == 2'd3) |=>
        (addr_o == AW'($past(ptr_c) + $past(disp_c)) && !wb_en_o));

    assert_prog_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && prog_i) |=>
        (wb_idx_o == IDX_W'(Z_IDX) && addr_o == $past(ptr_c) && (wb_en_o == ($past(mode_i) == 2'd2))));

    assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (strb_o == $past(req_i)));

    assert_wb_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> strb_o);

    assert_even_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !prog_i) |=> (wb_idx_o == ($past(ptr_idx_i) & ~IDX_W'(1))));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(
    .BYTE_W(BYTE_W), .DISP_W(DISP_W), .IDX_W(IDX_W), .Z_IDX(Z_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prog_i(prog_i), .mode_i(mode_i),
    .disp_i(disp_i), .ptr_lo_i(ptr_lo_i), .ptr_hi_i(ptr_hi_i), .ptr_idx_i(ptr_idx_i),
    .strb_o(strb_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_lo_o(wb_lo_o),
    .wb_hi_o(wb_hi_o), .wb_idx_o(wb_idx_o)
);

// File: tb/ptr_addr_gen_bench.sv
// Self-checking sweep bench for ptr_addr_gen; expected values computed here.
module ptr_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        prog_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [5:0]  disp_i = 6'd0;
    logic [7:0]  ptr_lo_i = 8'd0;
    logic [7:0]  ptr_hi_i = 8'd0;
    logic [4:0]  ptr_idx_i = 5'd0;
    logic        strb_o;
    logic [15:0] addr_o;
    logic        wb_en_o;
    logic [7:0]  wb_lo_o;
    logic [7:0]  wb_hi_o;
    logic [4:0]  wb_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ptr_addr_gen u_ptr_addr_gen (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one request and check its result one cycle later.
    task automatic apply(input logic [15:0] p, input logic [1:0] m, input logic pg,
                         input logic [5:0] d, input logic [4:0] ix);
        logic [15:0] e_addr, e_wb;
        logic        e_en;
        logic [4:0]  e_idx;
        string       tag;
        @(negedge clk);
        req_i = 1'b1; prog_i = pg; mode_i = m; disp_i = d;
        ptr_hi_i = p[15:8]; ptr_lo_i = p[7:0]; ptr_idx_i = ix;
        e_addr = p; e_wb = p; e_en = 1'b0;
        e_idx = pg ? 5'd30 : {ix[4:1], 1'b0};
        if (pg) begin
            tag = "R7";
            if (m == 2'd2) begin e_en = 1'b1; e_wb = p + 16'd1; end
        end else begin
            case (m)
                2'd0: tag = "R2";
                2'd1: begin tag = "R3"; e_addr = p - 16'd1; e_wb = e_addr; e_en = 1'b1; end
                2'd2: begin tag = "R4"; e_wb = p + 16'd1; e_en = 1'b1; end
                default: begin tag = "R5"; e_addr = p + {10'd0, d}; end
            endcase
        end
        @(negedge clk);
        req_i = 1'b0;
        check({tag, "/R8 strobe"}, 64'(strb_o), 64'd1);
        check({tag, " addr"}, 64'(addr_o), 64'(e_addr));
        check({tag, " wb_en"}, 64'(wb_en_o), 64'(e_en));
        if (e_en) check({tag, " wb value"}, 64'({wb_hi_o, wb_lo_o}), 64'(e_wb));
        check({tag, "/R9 wb_idx"}, 64'(wb_idx_o), 64'(e_idx));
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R8 idle strobe", 64'(strb_o), 64'd0);
        check("R8 idle wb_en", 64'(wb_en_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset strobe", 64'(strb_o), 64'd0);
        check("R1 reset wb_en", 64'(wb_en_o), 64'd0);
        check("R1 reset addr", 64'(addr_o), 64'd0);
        rst_n = 1'b1;
        // R6 wrap points
        apply(16'h0000, 2'd1, 1'b0, 6'd0, 5'd26);
        apply(16'hFFFF, 2'd2, 1'b0, 6'd0, 5'd28);
        apply(16'hFFF0, 2'd3, 1'b0, 6'd63, 5'd30);
        apply(16'hFFFF, 2'd2, 1'b1, 6'd5, 5'd3);
        apply(16'h0000, 2'd1, 1'b1, 6'd5, 5'd3);
        idle_check();
        // Sweep of pointers, modes, both paths, all displacements.
        for (int i = 0; i < 256; i++) begin
            for (int m = 0; m < 4; m++) begin
                for (int pg = 0; pg < 2; pg++) begin
                    logic [15:0] p;
                    p = 16'(i * 257 + (m * 4099));
                    apply(p, 2'(m), 1'(pg), 6'(i + m), 5'(i + m));
                end
            end
            if (i % 16 == 0) idle_check();
        end
        for (int d = 0; d < 64; d++) apply(16'hFFE0 + 16'(d), 2'd3, 1'b0, 6'(d), 5'd27);
        idle_check();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule